// File: doc/BRIEF.md
# Address-Type Field Checker for Inbound Request Headers

This block sits on a downstream-facing port and inspects the first header doubleword of every inbound request packet. It picks out the 2-bit address-type field, works out whether that value is legal for the packet's format and type, and sorts the packet into one of three classes: untranslated, translation request or already translated. An address type that is reserved, or one that is nonzero on a packet kind that may not carry it, gives a malformed verdict.

On top of the legality check, the block enforces a translation-blocking policy. A small table, written by the surrounding logic, lists the requester IDs that may use address translation. When blocking is on, a nonzero address type from a requester that is not in the table gets an unsupported-request verdict. A malformed packet is always reported as malformed, even if it would also be blocked.

The verdict, the class and an error pulse are registered and appear together with a one-cycle valid pulse on the clock edge after the header strobe. Payload handling and the generation of completions are left to neighbouring logic.

Top module: `at_field_checker`

## Requirements
- R1: Header bit layout: format = dw0[31:29], type = dw0[28:24], address type = dw0[11:10]. All other bits are ignored. Address type 00 is forwarded (verdict 00) with class 00 for every format and type, whatever the blocking state.
- R2: Address type 11 gives verdict malformed (01) and class 11, whatever the format and type.
- R3: A nonzero address type on a packet that is neither memory (type 00000 or 00001) nor atomic (type 01100, 01101 or 01110) gives verdict 01 and class 11. This covers IO, configuration, message and completion types.
- R4: Address type 01 is a translation request (class 01) only on a memory read header: format 000 or 001 with type 00000. On any other memory or atomic header it gives verdict 01 and class 11.
- R5: Address type 10 on a memory or atomic header gives class 10.
- R6: With blocking enabled, a legal nonzero address type from a requester ID that does not match a valid table entry gives verdict unsupported (10), with the class still set from the address type. A matching requester is forwarded (verdict 00).
- R7: With blocking disabled, the verdict is never 10.
- R8: When a header is both malformed and blocked, the verdict is 01.
- R9: Verdict, class and error appear one clock after the header strobe, together with a one-cycle valid pulse. The error is high exactly when the valid pulse carries a verdict other than 00.
- R10: The table has 8 entries, each a 16-bit requester ID plus a valid bit. A write (enable, index, ID, set flag) stores the ID and sets the valid bit to the set flag. A header in the same cycle as a write still sees the old contents. Reset clears every valid bit.
- R11: In a cycle after a cycle without a header strobe, valid and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_vld | input | 1 | Header strobe, one cycle per packet |
| hdr_dw0 | input | 32 | First header doubleword |
| hdr_rid | input | 16 | Requester ID of the packet |
| blk_en | input | 1 | Translation-blocking enable |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | 3 | Table entry index |
| tbl_rid | input | 16 | Requester ID to store |
| tbl_set | input | 1 | Valid bit to store with the entry |
| vrd_vld | output | 1 | Verdict valid pulse |
| vrd_code | output | 2 | Verdict: 00 forward, 01 malformed, 10 unsupported request |
| vrd_class | output | 2 | Class: 00 untranslated, 01 translation request, 10 translated, 11 none |
| vrd_err | output | 1 | Error pulse with a non-forward verdict |

## Verification
The assertions check on every cycle the one-cycle timing of the valid pulse, the quiet outputs after idle cycles, the error-to-verdict relation, and the header-only rules: a reserved type is malformed, type 00 is forwarded, a nonzero type on a configuration header is malformed, and no unsupported verdict appears with blocking off. The table-dependent outcomes can only be shown by the bench's scenarios. These are which requesters are blocked, clearing an entry, the old contents being seen on a write cycle, and reset clearing the table. The bench also covers the full sweep over format, type, address type, blocking and table hit, and there the precedence of malformed over unsupported is shown.

// File: rtl/at_chk_pkg.sv
package at_chk_pkg;

    typedef enum logic [1:0] {
        VRD_PASS  = 2'b00,
        VRD_MALF  = 2'b01,
        VRD_UNSUP = 2'b10
    } vrd_e;

    typedef enum logic [1:0] {
        CLS_UNTRANS = 2'b00,
        CLS_XREQ    = 2'b01,
        CLS_XLATED  = 2'b10,
        CLS_NONE    = 2'b11
    } cls_e;

    localparam logic [1:0] ADT_DEFAULT = 2'b00;
    localparam logic [1:0] ADT_REQUEST = 2'b01;
    localparam logic [1:0] ADT_DONE    = 2'b10;
    localparam logic [1:0] ADT_RSVD    = 2'b11;

endpackage

// File: rtl/at_rid_table.sv
module at_rid_table #(
    parameter int NUM_ENT = 8,
    parameter int RID_W   = 16,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RID_W-1:0] wr_rid,
    input  logic             wr_set,
    input  logic [RID_W-1:0] look_rid,
    output logic             hit
);

    logic [RID_W-1:0] ent_rid [NUM_ENT];
    logic [NUM_ENT-1:0] ent_vld;
    logic [NUM_ENT-1:0] match;

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_vld[g] <= 1'b0;
                ent_rid[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_vld[g] <= wr_set;
                ent_rid[g] <= wr_rid;
            end
        end

        assign match[g] = ent_vld[g] && (ent_rid[g] == look_rid);
    end

    assign hit = |match;

endmodule

// File: rtl/at_hdr_decode.sv
module at_hdr_decode
    import at_chk_pkg::*;
(
    input  logic [31:0] dw0,
    input  logic        blk_en,
    input  logic        rid_hit,
    output vrd_e        vrd,
    output cls_e        cls
);

    logic [2:0] fmt;
    logic [4:0] typ;
    logic [1:0] adt;
    logic       is_mem;
    logic       is_atomic;
    logic       is_mrd;
    logic       bad_rsvd;
    logic       bad_kind;
    logic       bad_req;
    logic       malformed;
    logic       blocked;
    logic       unused_hdr_bits;

    assign fmt = dw0[31:29];
    assign typ = dw0[28:24];
    assign adt = dw0[11:10];
    assign unused_hdr_bits = ^{dw0[23:12], dw0[9:0]};

    always_comb begin
        is_mem    = (typ == 5'b00000) || (typ == 5'b00001);
        is_atomic = (typ == 5'b01100) || (typ == 5'b01101) || (typ == 5'b01110);
        is_mrd    = (typ == 5'b00000) && (fmt[2:1] == 2'b00);
    end

    always_comb begin
        bad_rsvd  = (adt == ADT_RSVD);
        bad_kind  = (adt != ADT_DEFAULT) && !(is_mem || is_atomic);
        bad_req   = (adt == ADT_REQUEST) && !is_mrd;
        malformed = bad_rsvd || bad_kind || bad_req;
        blocked   = blk_en && (adt != ADT_DEFAULT) && !rid_hit;
    end

    always_comb begin
        if (malformed) begin
            vrd = VRD_MALF;
        end else if (blocked) begin
            vrd = VRD_UNSUP;
        end else begin
            vrd = VRD_PASS;
        end
    end

    always_comb begin
        if (malformed) begin
            cls = CLS_NONE;
        end else begin
            unique case (adt)
                ADT_DEFAULT: cls = CLS_UNTRANS;
                ADT_REQUEST: cls = CLS_XREQ;
                ADT_DONE:    cls = CLS_XLATED;
                default:     cls = CLS_NONE;
            endcase
        end
    end

endmodule

// File: rtl/at_verdict_reg.sv
module at_verdict_reg
    import at_chk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_vld,
    input  vrd_e       in_vrd,
    input  cls_e       in_cls,
    output logic       out_vld,
    output vrd_e       out_vrd,
    output cls_e       out_cls,
    output logic       out_err
);

    logic nxt_err;

    always_comb begin
        nxt_err = in_vld && (in_vrd != VRD_PASS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_err <= 1'b0;
            out_vrd <= VRD_PASS;
            out_cls <= CLS_UNTRANS;
        end else begin
            out_vld <= in_vld;
            out_err <= nxt_err;
            if (in_vld) begin
                out_vrd <= in_vrd;
                out_cls <= in_cls;
            end
        end
    end

endmodule

// File: rtl/at_field_checker.sv
module at_field_checker
    import at_chk_pkg::*;
#(
    parameter int NUM_ENT = 8,
    parameter int RID_W   = 16,
    localparam int IDX_W  = $clog2(NUM_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hdr_vld,
    input  logic [31:0]      hdr_dw0,
    input  logic [RID_W-1:0] hdr_rid,
    input  logic             blk_en,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [RID_W-1:0] tbl_rid,
    input  logic             tbl_set,
    output logic             vrd_vld,
    output logic [1:0]       vrd_code,
    output logic [1:0]       vrd_class,
    output logic             vrd_err
);

    logic rid_hit;
    vrd_e dec_vrd;
    cls_e dec_cls;
    vrd_e reg_vrd;
    cls_e reg_cls;

    at_rid_table #(
        .NUM_ENT (NUM_ENT),
        .RID_W   (RID_W)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_rid   (tbl_rid),
        .wr_set   (tbl_set),
        .look_rid (hdr_rid),
        .hit      (rid_hit)
    );

    at_hdr_decode u_decode (
        .dw0     (hdr_dw0),
        .blk_en  (blk_en),
        .rid_hit (rid_hit),
        .vrd     (dec_vrd),
        .cls     (dec_cls)
    );

    at_verdict_reg u_vreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (hdr_vld),
        .in_vrd  (dec_vrd),
        .in_cls  (dec_cls),
        .out_vld (vrd_vld),
        .out_vrd (reg_vrd),
        .out_cls (reg_cls),
        .out_err (vrd_err)
    );

    assign vrd_code  = reg_vrd;
    assign vrd_class = reg_cls;

endmodule

// File: rtl/at_field_checker_chk.sv
module at_field_checker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        hdr_vld,
    input logic [31:0] hdr_dw0,
    input logic        blk_en,
    input logic        vrd_vld,
    input logic [1:0]  vrd_code,
    input logic [1:0]  vrd_class,
    input logic        vrd_err
);

    p_vld_pipe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_vld |=> vrd_vld);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_vld |=> (!vrd_vld && !vrd_err));

    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vrd_vld |-> (vrd_err == (vrd_code != 2'b00)));

    p_rsvd_malf_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld && hdr_dw0[11:10] == 2'b11) |=> (vrd_code == 2'b01 && vrd_class == 2'b11));

    p_untrans_fwd_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld && hdr_dw0[11:10] == 2'b00) |=> (vrd_code == 2'b00 && vrd_class == 2'b00));

    p_cfg_malf_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld && hdr_dw0[28:25] == 4'b0010 && hdr_dw0[11:10] != 2'b00) |=> (vrd_code == 2'b01));

    p_noblock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld && !blk_en) |=> (vrd_code != 2'b10));

endmodule

bind at_field_checker at_field_checker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hdr_vld   (hdr_vld),
    .hdr_dw0   (hdr_dw0),
    .blk_en    (blk_en),
    .vrd_vld   (vrd_vld),
    .vrd_code  (vrd_code),
    .vrd_class (vrd_class),
    .vrd_err   (vrd_err)
);

// File: tb/at_field_checker_tb.sv
module at_field_checker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hdr_vld = 1'b0;
    logic [31:0] hdr_dw0 = '0;
    logic [15:0] hdr_rid = '0;
    logic        blk_en = 1'b0;
    logic        tbl_we = 1'b0;
    logic [2:0]  tbl_idx = '0;
    logic [15:0] tbl_rid = '0;
    logic        tbl_set = 1'b0;
    logic        vrd_vld;
    logic [1:0]  vrd_code;
    logic [1:0]  vrd_class;
    logic        vrd_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    localparam logic [15:0] RID_A   = 16'h1234;
    localparam logic [15:0] RID_B   = 16'hBEEF;
    localparam logic [15:0] RID_OUT = 16'h0BAD;

    always #2.5 clk = ~clk;

    at_field_checker u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hdr_vld   (hdr_vld),
        .hdr_dw0   (hdr_dw0),
        .hdr_rid   (hdr_rid),
        .blk_en    (blk_en),
        .tbl_we    (tbl_we),
        .tbl_idx   (tbl_idx),
        .tbl_rid   (tbl_rid),
        .tbl_set   (tbl_set),
        .vrd_vld   (vrd_vld),
        .vrd_code  (vrd_code),
        .vrd_class (vrd_class),
        .vrd_err   (vrd_err)
    );

    task automatic check(string tag, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {vld,err,code,class} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Expected {vld, err, code, class} for a header, from the requirements.
    function automatic logic [5:0] expect_of(logic [2:0] f, logic [4:0] t, logic [1:0] a,
                                             logic blk, logic hit, output string tag);
        logic elig, mrd, malf, unsup;
        logic [1:0] code, cls;
        elig  = (t == 5'd0) || (t == 5'd1) || (t >= 5'd12 && t <= 5'd14);
        mrd   = (t == 5'd0) && (f < 3'd2);
        malf  = (a == 2'd3) || (a != 2'd0 && !elig) || (a == 2'd1 && !mrd);
        unsup = !malf && blk && (a != 2'd0) && !hit;
        code  = malf ? 2'b01 : (unsup ? 2'b10 : 2'b00);
        cls   = malf ? 2'b11 : a;
        if (malf && blk && !hit && a != 2'd0) tag = "R8 malformed over blocked";
        else if (a == 2'd3)                  tag = "R2 reserved type";
        else if (malf && !elig)              tag = "R3 nonzero on other kind";
        else if (malf)                       tag = "R4 request off memory read";
        else if (a == 2'd0)                  tag = "R1 untranslated";
        else if (blk)                        tag = "R6 blocking table";
        else if (a == 2'd1)                  tag = "R7 request unblocked";
        else                                 tag = "R5 translated unblocked";
        return {1'b1, code != 2'b00, code, cls};
    endfunction

    function automatic logic [31:0] mk_dw0(logic [2:0] f, logic [4:0] t, logic [1:0] a);
        return {f, t, 12'hA5C, a, 10'h2B7};
    endfunction

    // Entered at a falling edge; leaves at the next falling edge with outputs checked.
    task automatic send(logic [2:0] f, logic [4:0] t, logic [1:0] a, logic [15:0] rid,
                        logic blk, logic hit, string extra);
        string tg;
        logic [5:0] exp;
        hdr_vld = 1'b1;
        hdr_dw0 = mk_dw0(f, t, a);
        hdr_rid = rid;
        blk_en  = blk;
        exp = expect_of(f, t, a, blk, hit, tg);
        @(negedge clk);
        hdr_vld = 1'b0;
        tbl_we  = 1'b0;
        check({tg, " R9 ", extra}, {vrd_vld, vrd_err, vrd_code, vrd_class}, exp);
    endtask

    task automatic tbl_write(logic [2:0] idx, logic [15:0] rid, logic set);
        tbl_we = 1'b1; tbl_idx = idx; tbl_rid = rid; tbl_set = set;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset state", {vrd_vld, vrd_err, vrd_code, vrd_class}, 6'b000000);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: fill two entries
        tbl_write(3'd3, RID_A, 1'b1);
        tbl_write(3'd7, RID_B, 1'b1);
        @(negedge clk);
        check("R11 idle", {vrd_vld, vrd_err, vrd_code, vrd_class}, 6'b000000);

        // Exhaustive sweep over blocking, hit, format, type and address type.
        for (int b = 0; b < 2; b++) begin
            for (int h = 0; h < 2; h++) begin
                for (int f = 0; f < 8; f++) begin
                    for (int t = 0; t < 32; t++) begin
                        for (int a = 0; a < 4; a++) begin
                            send(3'(f), 5'(t), 2'(a), (h != 0) ? RID_B : RID_OUT,
                                 b[0], h[0], "sweep");
                        end
                    end
                end
            end
        end
        @(negedge clk);
        check("R11 idle after sweep", {vrd_vld, vrd_err}, 6'b0);

        // R10: first entry also hits
        send(3'b010, 5'd0, 2'd2, RID_A, 1'b1, 1'b1, "R10 entry 3 hit");

        // R10: clearing entry 7 makes RID_B blocked
        tbl_write(3'd7, RID_B, 1'b0);
        send(3'b010, 5'd0, 2'd2, RID_B, 1'b1, 1'b0, "R10 entry cleared");

        // R10: write in the same cycle as a header sees old contents
        tbl_we = 1'b1; tbl_idx = 3'd0; tbl_rid = 16'h5555; tbl_set = 1'b1;
        send(3'b011, 5'd12, 2'd2, 16'h5555, 1'b1, 1'b0, "R10 same-cycle write old");
        send(3'b011, 5'd12, 2'd2, 16'h5555, 1'b1, 1'b1, "R10 write seen next cycle");

        // R10: reset clears the table
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 R11 outputs in reset", {vrd_vld, vrd_err, vrd_code, vrd_class}, 6'b0);
        rst_n = 1'b1;
        @(negedge clk);
        send(3'b000, 5'd0, 2'd1, RID_A, 1'b1, 1'b0, "R10 reset cleared entry 3");
        send(3'b000, 5'd0, 2'd1, 16'h5555, 1'b1, 1'b0, "R10 reset cleared entry 0");
        send(3'b000, 5'd0, 2'd1, 16'h5555, 1'b0, 1'b0, "R7 unblocked after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=expired expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule